// File: doc/BRIEF.md
# PC-Relative Address Unit

This block executes one major opcode of a 64-bit RISC core: the group of instructions that form values or load addresses relative to the program counter. Each cycle it can accept one 32-bit instruction word together with the current PC and a flag that says whether 64-bit operation is enabled. A sub-opcode field of variable width (two, three or five bits, starting at bit 20) chooses the operation. Each operation uses its own immediate width and scale.

The address-forming operations finish in the cycle the instruction arrives and raise a register write request. The loads raise a load request and move the small control machine from `IDLE` to `WAIT_LOAD`. In `WAIT_LOAD` the unit refuses new instructions. When the load response arrives it sign- or zero-extends the data, writes it to the destination register and takes the transition back to `IDLE`. There are two named transitions: `ISSUE` (from `IDLE` on an accepted load) and `RETIRE` (from `WAIT_LOAD` on a response). Reset places the machine in `IDLE`. Encodings that are illegal raise a reserved-instruction flag and start no other action.

Top module: `pcrel_unit`

## Requirements
- R1: An instruction whose bits 31:26 are not 0x3B produces no register write, no load request and no exception.
- R2: When bits 20:19 are 00, the destination register (bits 25:21) receives PC plus the sign-extended bits 18:0 multiplied by 4.
- R3: When bits 20:16 are 0x1E, the destination receives PC plus the sign-extended bits 15:0 shifted left by 16.
- R4: When bits 20:16 are 0x1F, the destination receives the same sum as in R3 with bits 15:0 forced to zero.
- R5: For the three address-forming operations, a destination index of zero suppresses the register write and raises no exception.
- R6: When bits 20:19 are 01, a word load is requested (ld_size 0, ld_signed 1) at PC plus sign-extended bits 18:0 times 4. The response's low 32 bits are sign-extended and written to the destination.
- R7: When bits 20:19 are 10 and mode64 is 1, a word load is requested as in R6 with ld_signed 0, and the response is zero-extended. With mode64 at 0 this encoding raises the exception instead.
- R8: When bits 20:18 are 110 and mode64 is 1, a doubleword load (ld_size 1) is requested at (PC with bits 2:0 cleared) plus the sign-extended bits 17:0 times 8. The full 64-bit response is written unchanged. With mode64 at 0 this encoding raises the exception instead.
- R9: Under opcode 0x3B, any encoding not covered by R2 to R8 raises rsvd_exc and issues neither a write nor a load. At most one of wr_en, ld_req and rsvd_exc is high in any cycle.
- R10: From a load request until its response, insn_ready is low and instructions presented on the input have no effect. A response while `IDLE` is ignored.
- R11: All address sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction is presented |
| insn_ready | output | 1 | High in IDLE; an instruction is taken when valid and ready |
| insn | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| mode64 | input | 1 | 64-bit operation enabled |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Value to write |
| ld_req | output | 1 | Load request, one cycle |
| ld_addr | output | 64 | Load address |
| ld_size | output | 1 | 0 word, 1 doubleword |
| ld_signed | output | 1 | Sign-extend a word response |
| ld_dest | output | 5 | Register the load will write |
| ld_rsp_valid | input | 1 | Load data returned |
| ld_rsp_data | input | 64 | Returned data |
| rsvd_exc | output | 1 | Reserved-instruction exception |

## Verification
The bench sweeps all 32 values of bits 20:16 against six low-halfword immediates. These include zero, the extremes of each sign and minus one, so every sub-opcode is exercised with both signs of every immediate width. It uses five PCs, including one near the top of the address space to force wraparound and one that is not 8-byte aligned to show the doubleword alignment. Each combination is run with both mode64 values and with destination zero and non-zero, which separates the mode-gated loads from their reserved twins and shows the write suppression. Load responses alternate between data with bit 31 set and clear, which distinguishes sign extension from zero extension. During each wait, a legal instruction is presented that must not be decoded. Foreign major opcodes and stray responses in `IDLE` are also driven.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADDPC,
        K_AUPC,
        K_ALUPC,
        K_LDW,
        K_LDWU,
        K_LDD,
        K_RSVD
    } pcrel_kind_e;

    typedef enum logic [0:0] {
        IDLE      = 1'b0,
        WAIT_LOAD = 1'b1
    } pcrel_state_e;

    function automatic logic is_load(input pcrel_kind_e k);
        return (k == K_LDW) || (k == K_LDWU) || (k == K_LDD);
    endfunction

    function automatic logic is_form(input pcrel_kind_e k);
        return (k == K_ADDPC) || (k == K_AUPC) || (k == K_ALUPC);
    endfunction

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
    import pcrel_pkg::*;
#(
    parameter logic [5:0] MAJOR = 6'h3B
) (
    input  logic [5:0]  major,
    input  logic [4:0]  sub,
    input  logic        mode64,
    output pcrel_kind_e kind
);
    always_comb begin
        kind = K_RSVD;
        if (major != MAJOR) begin
            kind = K_NONE;
        end else begin
            unique case (sub[4:3])
                2'b00: kind = K_ADDPC;
                2'b01: kind = K_LDW;
                2'b10: kind = mode64 ? K_LDWU : K_RSVD;
                2'b11: begin
                    if (sub[2:0] == 3'b110)      kind = K_AUPC;
                    else if (sub[2:0] == 3'b111) kind = K_ALUPC;
                    else if (!sub[2])            kind = mode64 ? K_LDD : K_RSVD;
                    else                         kind = K_RSVD;
                end
                default: kind = K_RSVD;
            endcase
        end
    end
endmodule

// File: rtl/pcrel_agen.sv
module pcrel_agen
    import pcrel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pc,
    input  logic [18:0]     imm,
    input  pcrel_kind_e     kind,
    output logic [XLEN-1:0] addr
);
    localparam int WSH = 2;
    localparam int DSH = 3;
    localparam int USH = 16;

    logic [XLEN-1:0] off_w, off_d, off_u, pc_dal, sum_u;

    always_comb begin
        off_w  = {{(XLEN-19-WSH){imm[18]}}, imm[18:0], {WSH{1'b0}}};
        off_d  = {{(XLEN-18-DSH){imm[17]}}, imm[17:0], {DSH{1'b0}}};
        off_u  = {{(XLEN-16-USH){imm[15]}}, imm[15:0], {USH{1'b0}}};
        pc_dal = {pc[XLEN-1:DSH], {DSH{1'b0}}};
        sum_u  = pc + off_u;
        unique case (kind)
            K_AUPC:  addr = sum_u;
            K_ALUPC: addr = {sum_u[XLEN-1:USH], {USH{1'b0}}};
            K_LDD:   addr = pc_dal + off_d;
            default: addr = pc + off_w;
        endcase
    end
endmodule

// File: rtl/pcrel_ldext.sv
module pcrel_ldext
    import pcrel_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0] raw,
    input  pcrel_kind_e     kind,
    output logic [XLEN-1:0] ext
);
    always_comb begin
        unique case (kind)
            K_LDW:   ext = {{(XLEN-WLEN){raw[WLEN-1]}}, raw[WLEN-1:0]};
            K_LDWU:  ext = {{(XLEN-WLEN){1'b0}}, raw[WLEN-1:0]};
            default: ext = raw;
        endcase
    end
endmodule

// File: rtl/pcrel_unit.sv
module pcrel_unit
    import pcrel_pkg::*;
#(
    parameter int         XLEN  = 64,
    parameter logic [5:0] MAJOR = 6'h3B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    output logic            insn_ready,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] pc,
    input  logic            mode64,
    output logic            wr_en,
    output logic [4:0]      wr_idx,
    output logic [XLEN-1:0] wr_data,
    output logic            ld_req,
    output logic [XLEN-1:0] ld_addr,
    output logic            ld_size,
    output logic            ld_signed,
    output logic [4:0]      ld_dest,
    input  logic            ld_rsp_valid,
    input  logic [XLEN-1:0] ld_rsp_data,
    output logic            rsvd_exc
);
    localparam int RIDX = 5;

    pcrel_state_e    state, state_nx;
    pcrel_kind_e     kind, pend_kind;
    logic [RIDX-1:0] rd, pend_rd;
    logic [XLEN-1:0] addr, ext;
    logic            accept;

    assign rd = insn[25:21];

    pcrel_decode #(.MAJOR(MAJOR)) u_dec (
        .major (insn[31:26]),
        .sub   (insn[20:16]),
        .mode64(mode64),
        .kind  (kind)
    );

    pcrel_agen #(.XLEN(XLEN)) u_agen (
        .pc  (pc),
        .imm (insn[18:0]),
        .kind(kind),
        .addr(addr)
    );

    pcrel_ldext #(.XLEN(XLEN)) u_ext (
        .raw (ld_rsp_data),
        .kind(pend_kind),
        .ext (ext)
    );

    assign accept = (state == IDLE) && insn_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= IDLE;
            pend_kind <= K_NONE;
            pend_rd   <= '0;
        end else begin
            state <= state_nx;
            if (accept && is_load(kind)) begin
                pend_kind <= kind;
                pend_rd   <= rd;
            end
        end
    end

    // Transitions: ISSUE and RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:      if (accept && is_load(kind)) state_nx = WAIT_LOAD;
            WAIT_LOAD: if (ld_rsp_valid)            state_nx = IDLE;
            default:   state_nx = IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        insn_ready = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = '0;
        wr_data    = '0;
        ld_req     = 1'b0;
        ld_addr    = '0;
        ld_size    = 1'b0;
        ld_signed  = 1'b0;
        ld_dest    = '0;
        rsvd_exc   = 1'b0;
        unique case (state)
            IDLE: begin
                insn_ready = 1'b1;
                if (insn_valid) begin
                    if (is_form(kind)) begin
                        wr_en   = (rd != '0);
                        wr_idx  = rd;
                        wr_data = addr;
                    end else if (is_load(kind)) begin
                        ld_req    = 1'b1;
                        ld_addr   = addr;
                        ld_size   = (kind == K_LDD);
                        ld_signed = (kind == K_LDW);
                        ld_dest   = rd;
                    end else if (kind == K_RSVD) begin
                        rsvd_exc = 1'b1;
                    end
                end
            end
            WAIT_LOAD: begin
                if (ld_rsp_valid) begin
                    wr_en   = 1'b1;
                    wr_idx  = pend_rd;
                    wr_data = ext;
                end
            end
            default: ;
        endcase
    end

    assert_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_ready && insn[31:26] != MAJOR) |-> !(wr_en || ld_req || rsvd_exc));

    assert_lowclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && insn_ready && insn[31:26] == MAJOR && insn[20:16] == 5'h1F) |-> (wr_data[15:0] == 16'h0));

    assert_rdzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && insn_ready) |-> (wr_idx != '0));

    assert_mode32_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !mode64) |-> (ld_signed && !ld_size));

    assert_dalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size) |-> (ld_addr[2:0] == 3'b000));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, ld_req, rsvd_exc}));

    assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> !insn_ready);

endmodule

// File: tb/pcrel_unit_tb.sv
module pcrel_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_valid;
    logic        insn_ready;
    logic [31:0] insn;
    logic [63:0] pc;
    logic        mode64;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic        ld_req;
    logic [63:0] ld_addr;
    logic        ld_size;
    logic        ld_signed;
    logic [4:0]  ld_dest;
    logic        ld_rsp_valid;
    logic [63:0] ld_rsp_data;
    logic        rsvd_exc;

    int checks = 0;
    int errors = 0;
    int nresp  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcrel_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
        .insn(insn), .pc(pc), .mode64(mode64), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_signed(ld_signed), .ld_dest(ld_dest), .ld_rsp_valid(ld_rsp_valid),
        .ld_rsp_data(ld_rsp_data), .rsvd_exc(rsvd_exc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // kinds: 0 foreign, 1 addpc, 2 aupc, 3 alupc, 4 ldw, 5 ldwu, 6 ldd, 7 reserved
    task automatic run_one(input logic [31:0] w, input logic [63:0] p, input bit m);
        int k;
        string tag;
        logic [63:0] ea, rdata, wexp;
        logic [4:0]  rd;
        rd = w[25:21];
        if (w[31:26] != 6'h3B)           k = 0;
        else if (w[20:19] == 2'b00)      k = 1;
        else if (w[20:19] == 2'b01)      k = 4;
        else if (w[20:19] == 2'b10)      k = m ? 5 : 7;
        else if (w[20:16] == 5'h1E)      k = 2;
        else if (w[20:16] == 5'h1F)      k = 3;
        else if (w[20:18] == 3'b110)     k = m ? 6 : 7;
        else                             k = 7;
        case (k)
            0: tag = "R1";
            1: tag = (rd == 0) ? "R5" : "R2";
            2: tag = (rd == 0) ? "R5" : "R3";
            3: tag = (rd == 0) ? "R5" : "R4";
            4: tag = "R6";
            5: tag = "R7";
            6: tag = "R8";
            default: tag = (w[20:19] == 2'b10) ? "R7" : ((w[20:18] == 3'b110) ? "R8" : "R9");
        endcase
        case (k)
            2: ea = p + (longint'($signed(w[15:0])) <<< 16);
            3: ea = (p + (longint'($signed(w[15:0])) <<< 16)) & ~64'hFFFF;
            6: ea = (p & ~64'h7) + (longint'($signed(w[17:0])) <<< 3);
            default: ea = p + (longint'($signed(w[18:0])) <<< 2);
        endcase
        @(posedge clk); #1;
        insn_valid = 1'b1; insn = w; pc = p; mode64 = m; ld_rsp_valid = 1'b0;
        @(negedge clk);
        chk({tag, " ready"}, 64'(insn_ready), 64'd1);
        chk({tag, " wr_en"}, 64'(wr_en), 64'((k >= 1 && k <= 3) && rd != 0));
        chk({tag, " ld_req"}, 64'(ld_req), 64'(k >= 4 && k <= 6));
        chk({tag, " rsvd_exc"}, 64'(rsvd_exc), 64'(k == 7));
        if ((k >= 1 && k <= 3) && rd != 0) begin
            chk({tag, " wr_idx"}, 64'(wr_idx), 64'(rd));
            chk({tag, " wr_data R11"}, wr_data, ea);
        end
        if (k >= 4 && k <= 6) begin
            chk({tag, " ld_addr R11"}, ld_addr, ea);
            chk({tag, " ld_size"}, 64'(ld_size), 64'(k == 6));
            chk({tag, " ld_signed"}, 64'(ld_signed), 64'(k == 4));
            chk({tag, " ld_dest"}, 64'(ld_dest), 64'(rd));
            // R10: a legal address-forming insn during the wait must be ignored
            @(posedge clk); #1;
            insn = {6'h3B, 5'd9, 5'd0, 16'h0040};
            @(negedge clk);
            chk("R10 ready in wait", 64'(insn_ready), 64'd0);
            chk("R10 wr_en in wait", 64'(wr_en), 64'd0);
            chk("R10 ld_req in wait", 64'(ld_req), 64'd0);
            nresp++;
            rdata = nresp[0] ? 64'hFEDC_BA98_8765_4321 : 64'h0123_4567_1234_5678;
            case (k)
                4: wexp = {{32{rdata[31]}}, rdata[31:0]};
                5: wexp = {32'h0, rdata[31:0]};
                default: wexp = rdata;
            endcase
            @(posedge clk); #1;
            ld_rsp_valid = 1'b1; ld_rsp_data = rdata;
            @(negedge clk);
            chk({tag, " resp wr_en"}, 64'(wr_en), 64'd1);
            chk({tag, " resp wr_idx"}, 64'(wr_idx), 64'(rd));
            chk({tag, " resp wr_data"}, wr_data, wexp);
            @(posedge clk); #1;
            ld_rsp_valid = 1'b0; insn_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] pcs [5];
        logic [15:0] lows [6];
        logic [4:0]  rds [3];
        pcs[0] = 64'h0;
        pcs[1] = 64'h0000_0000_1000_0004;
        pcs[2] = 64'hFFFF_FFFF_FFFF_FFFC;
        pcs[3] = 64'h8000_0000_0000_0006;
        pcs[4] = 64'h0000_0000_7FFF_FFF8;
        lows[0] = 16'h0000; lows[1] = 16'h7FFF; lows[2] = 16'h8000;
        lows[3] = 16'hFFFF; lows[4] = 16'h1234; lows[5] = 16'hA5C3;
        rds[0] = 5'd0; rds[1] = 5'd17; rds[2] = 5'd31;

        rst_n = 1'b0; insn_valid = 1'b0; insn = '0; pc = '0; mode64 = 1'b0;
        ld_rsp_valid = 1'b0; ld_rsp_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("reset ready R10", 64'(insn_ready), 64'd1);
        chk("reset wr_en R1", 64'(wr_en), 64'd0);
        chk("reset ld_req R6", 64'(ld_req), 64'd0);
        chk("reset rsvd R9", 64'(rsvd_exc), 64'd0);

        // R10: stray response in IDLE is ignored
        @(posedge clk); #1;
        ld_rsp_valid = 1'b1; ld_rsp_data = 64'h1111_2222_3333_4444;
        @(negedge clk);
        chk("R10 idle response", 64'(wr_en), 64'd0);
        @(posedge clk); #1 ld_rsp_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle after response", 64'(insn_ready), 64'd1);

        // R1: foreign major opcodes
        for (int op = 0; op < 64; op++) begin
            if (op != 'h3B) run_one({6'(op), 5'd4, 5'h1E, 16'h8001}, pcs[1], 1'b1);
        end

        // Main sweep: R2..R9, R11
        for (int s = 0; s < 32; s++)
            for (int li = 0; li < 6; li++)
                for (int pi = 0; pi < 5; pi++)
                    for (int mi = 0; mi < 2; mi++)
                        for (int ri = 0; ri < 3; ri++)
                            run_one({6'h3B, rds[ri], 5'(s), lows[li]}, pcs[pi], mi[0]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule